// File: doc/BRIEF.md
# SIMD Integer Multiply-High/Low Unit

This unit multiplies two 128-bit vector operands lane by lane. The register is read either as four 32-bit lanes or as two 64-bit lanes. Each lane forms the full double-width product and returns its upper half or its lower half. A control input chooses whether the operands are taken as two's-complement or as unsigned values. Lane k occupies bits [32k+31:32k] in word mode and bits [64k+63:64k] in doubleword mode. No carry crosses from one lane into the next.

A single datapath serves both lane sizes. Each 64-bit lane is built from four 33x33 signed partial-product multipliers. In doubleword mode the four partial products are summed into one 128-bit product. In word mode only the two diagonal partial products are used, one for each 32-bit element. The sign-extension bit of each 32-bit half is chosen from the element size and the signedness control.

The result passes through a register pipeline of `LATENCY` stages (default 2). An operation is accepted when `in_valid` and `in_ready` are both high at a rising edge. The pipeline never stalls, so `in_ready` is high whenever reset is low.

Top module: `simd_mulhl_unit`

## Requirements
- R1: With `in_dword`=0 and `in_high`=1, lane k of the result is bits [63:32] of the 64-bit product of the two 32-bit elements of lane k (for example, unsigned 0x80000000 times 4, 5, 6 and 7 gives 2, 2, 3 and 3).
- R2: With `in_dword`=1 and `in_high`=1, lane k of the result is bits [127:64] of the 128-bit product of the two 64-bit elements of lane k (for example, unsigned 0x1FFFFFFFFFFFFFFF times 32 gives 3).
- R3: With `in_dword`=1 and `in_high`=0, lane k of the result is bits [63:0] of the 128-bit product, and this value is the same for `in_signed`=0 and `in_signed`=1.
- R4: With `in_dword`=0 and `in_high`=0, lane k of the result is bits [31:0] of the 64-bit product of its elements.
- R5: With `in_signed`=1 the elements are two's-complement numbers; with `in_signed`=0 they are unsigned. This covers the most negative value, -1, 0 and the maximum unsigned value.
- R6: Each lane's result depends only on the elements of that lane at the positions given above. No carry or sign passes between lanes.
- R7: `out_valid` is high in exactly the cycle that comes `LATENCY` cycles after the cycle in which an operation was accepted, and it is low otherwise. `out_result` carries that operation's result in that cycle.
- R8: While `rst` is high, `in_ready` is low and `in_valid` is ignored; after reset `out_valid` stays low until an accepted operation arrives, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept (high outside reset) |
| in_a | input | DATA_W | First operand vector |
| in_b | input | DATA_W | Second operand vector |
| in_dword | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| in_high | input | 1 | 1: upper half of product, 0: lower half |
| out_valid | output | 1 | Result valid |
| out_result | output | DATA_W | Lane-wise selected product halves |

## Verification
Every one of the eight combinations of element size, signedness and half is swept over all pairs from a corner set: 0, 1, 2, -1, -2, the most negative value, the most positive value and a mid-range power of two. The corner values are rotated across lanes so that neighbouring lanes hold different extremes. Because the four partial products of a lane are sign-extended differently in each mode, these pairs separate a wrong extension bit or a wrong half from a correct one. Random operands, with random idle gaps between them, exercise carry propagation inside a lane and confirm that no carry escapes to the next lane. They also check the exact cycle of `out_valid`. The two worked unsigned cases are compared against literal values.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int SUB_W  = 32;
    localparam int EXT_W  = SUB_W + 1;
    localparam int PP_W   = 2 * EXT_W;
    localparam int LANE_W = 2 * SUB_W;
    localparam int PROD_W = 2 * LANE_W;

    typedef enum logic {
        ELEM_WORD  = 1'b0,
        ELEM_DWORD = 1'b1
    } elem_e;

    typedef struct packed {
        elem_e size;
        logic  sgn;
        logic  high;
    } mul_op_t;

    // extend a 32-bit half to 33 bits, replicating its top bit when asked
    function automatic logic [EXT_W-1:0] ext_half(input logic [SUB_W-1:0] v,
                                                  input logic as_signed);
        return {as_signed & v[SUB_W-1], v};
    endfunction

    // sign-extend a partial product to the full lane product width
    function automatic logic [PROD_W-1:0] widen_pp(input logic [PP_W-1:0] v);
        return {{(PROD_W-PP_W){v[PP_W-1]}}, v};
    endfunction

endpackage

// File: rtl/simd_pp_mul.sv
module simd_pp_mul #(
    parameter int W = 33
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    logic [2*W-1:0] a_w;
    logic [2*W-1:0] b_w;

    assign a_w = {{W{a[W-1]}}, a};
    assign b_w = {{W{b[W-1]}}, b};
    assign p   = a_w * b_w;
endmodule

// File: rtl/simd_dlane.sv
module simd_dlane
    import simd_mul_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  mul_op_t           op,
    output logic [LANE_W-1:0] y
);
    logic [EXT_W-1:0] ax [2];
    logic [EXT_W-1:0] bx [2];
    logic [PP_W-1:0]  pp [2][2];
    logic             ext_lo;
    logic [PROD_W-1:0] full;

    // the lower half is a number of its own only in word mode
    assign ext_lo = op.sgn & (op.size == ELEM_WORD);

    assign ax[0] = ext_half(a[SUB_W-1:0], ext_lo);
    assign bx[0] = ext_half(b[SUB_W-1:0], ext_lo);
    assign ax[1] = ext_half(a[LANE_W-1:SUB_W], op.sgn);
    assign bx[1] = ext_half(b[LANE_W-1:SUB_W], op.sgn);

    for (genvar gi = 0; gi < 2; gi++) begin : g_row
        for (genvar gj = 0; gj < 2; gj++) begin : g_col
            simd_pp_mul #(.W(EXT_W)) u_pp (
                .a (ax[gi]),
                .b (bx[gj]),
                .p (pp[gi][gj])
            );
        end
    end

    assign full = widen_pp(pp[0][0])
                + (widen_pp(pp[1][0]) << SUB_W)
                + (widen_pp(pp[0][1]) << SUB_W)
                + (widen_pp(pp[1][1]) << LANE_W);

    always_comb begin
        unique case ({op.size, op.high})
            {ELEM_DWORD, 1'b1}: y = full[PROD_W-1:LANE_W];
            {ELEM_DWORD, 1'b0}: y = full[LANE_W-1:0];
            {ELEM_WORD,  1'b1}: y = {pp[1][1][LANE_W-1:SUB_W], pp[0][0][LANE_W-1:SUB_W]};
            default:            y = {pp[1][1][SUB_W-1:0], pp[0][0][SUB_W-1:0]};
        endcase
    end
endmodule

// File: rtl/simd_delay_line.sv
module simd_delay_line #(
    parameter int W     = 128,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         vld [DEPTH];
    logic [W-1:0] dat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) begin
                vld[s] <= 1'b0;
                dat[s] <= '0;
            end
        end else begin
            vld[0] <= in_valid;
            if (in_valid) dat[0] <= in_data;
            for (int s = 1; s < DEPTH; s++) begin
                vld[s] <= vld[s-1];
                if (vld[s-1]) dat[s] <= dat[s-1];
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];
endmodule

// File: rtl/simd_mulhl_unit.sv
module simd_mulhl_unit
    import simd_mul_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              in_dword,
    input  logic              in_signed,
    input  logic              in_high,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int NUM_DL = DATA_W / LANE_W;

    mul_op_t           op;
    logic              accept;
    logic [DATA_W-1:0] comb_result;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;
    assign op.size  = in_dword ? ELEM_DWORD : ELEM_WORD;
    assign op.sgn   = in_signed;
    assign op.high  = in_high;

    for (genvar gl = 0; gl < NUM_DL; gl++) begin : g_lane
        simd_dlane u_lane (
            .a  (in_a[gl*LANE_W +: LANE_W]),
            .b  (in_b[gl*LANE_W +: LANE_W]),
            .op (op),
            .y  (comb_result[gl*LANE_W +: LANE_W])
        );
    end

    simd_delay_line #(.W(DATA_W), .DEPTH(LATENCY)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_data   (comb_result),
        .out_valid (out_valid),
        .out_data  (out_result)
    );
endmodule

// File: rtl/simd_mulhl_checker.sv
module simd_mulhl_checker #(
    parameter int DATA_W  = 128,
    parameter int LATENCY = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              in_dword,
    input logic              in_signed,
    input logic              in_high,
    input logic              out_valid,
    input logic [DATA_W-1:0] comb_y
);
    logic         seen [LATENCY];
    logic [63:0]  word_u;
    logic [127:0] dword_s;
    logic [63:0]  dword_lo;

    assign word_u   = {32'b0, in_a[31:0]} * {32'b0, in_b[31:0]};
    assign dword_s  = {{64{in_a[63]}}, in_a[63:0]} * {{64{in_b[63]}}, in_b[63:0]};
    assign dword_lo = in_a[63:0] * in_b[63:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < LATENCY; s++) seen[s] <= 1'b0;
        end else begin
            seen[0] <= in_valid & in_ready;
            for (int s = 1; s < LATENCY; s++) seen[s] <= seen[s-1];
        end
    end

    a_r1_word_high_unsigned: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dword && !in_signed && in_high) |-> (comb_y[31:0] == word_u[63:32]));

    a_r2_dword_high_signed: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dword && in_signed && in_high) |-> (comb_y[63:0] == dword_s[127:64]));

    a_r3_dword_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dword && !in_high) |-> (comb_y[63:0] == dword_lo));

    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == seen[LATENCY-1]);

    a_r8_no_ready_in_reset: assert property (@(posedge clk)
        rst |-> !in_ready);

    a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

bind simd_mulhl_unit simd_mulhl_checker #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_dword  (in_dword),
    .in_signed (in_signed),
    .in_high   (in_high),
    .out_valid (out_valid),
    .comb_y    (comb_result)
);

// File: tb/tb_simd_mulhl_unit.sv
`timescale 1ns/1ps
module tb_simd_mulhl_unit;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         in_dword = 1'b0;
    logic         in_signed = 1'b0;
    logic         in_high = 1'b0;
    logic         out_valid;
    logic [127:0] out_result;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    bit done = 0;

    int           q_due [$];
    logic [127:0] q_exp [$];
    string        q_tag [$];

    logic [31:0] c32 [8];
    logic [63:0] c64 [8];

    always #5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    simd_mulhl_unit #(.DATA_W(128), .LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_dword(in_dword), .in_signed(in_signed),
        .in_high(in_high), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b,
                                             input logic dw, input logic sg, input logic hi);
        logic [127:0] r = '0;
        if (!dw) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] x, y, p;
                x = {{32{sg & a[32*k+31]}}, a[32*k +: 32]};
                y = {{32{sg & b[32*k+31]}}, b[32*k +: 32]};
                p = x * y;
                r[32*k +: 32] = hi ? p[63:32] : p[31:0];
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                logic [127:0] x, y, p;
                x = {{64{sg & a[64*k+63]}}, a[64*k +: 64]};
                y = {{64{sg & b[64*k+63]}}, b[64*k +: 64]};
                p = x * y;
                r[64*k +: 64] = hi ? p[127:64] : p[63:0];
            end
        end
        return r;
    endfunction

    function automatic string mode_tag(input logic dw, input logic sg, input logic hi);
        string t;
        t = dw ? (hi ? "R2" : "R3") : (hi ? "R1" : "R4");
        if (sg) t = {t, "/R5"};
        return t;
    endfunction

    task automatic check1(input bit ok, input string tag, input logic [127:0] act,
                          input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        if (q_due.size() > 0 && q_due[0] == edge_cnt) begin
            check1(out_valid == 1'b1, "R7 valid", 128'(out_valid), 128'd1);
            check1(out_result == q_exp[0], q_tag[0], out_result, q_exp[0]);
            void'(q_due.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end else begin
            check1(out_valid == 1'b0, "R7 idle", 128'(out_valid), 128'd0);
        end
    endtask

    task automatic step(input logic v, input logic [127:0] a, input logic [127:0] b,
                        input logic dw, input logic sg, input logic hi,
                        input logic [127:0] exp, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        in_a      = a;
        in_b      = b;
        in_dword  = dw;
        in_signed = sg;
        in_high   = hi;
        if (v) begin
            q_due.push_back(edge_cnt + LAT);
            q_exp.push_back(exp);
            q_tag.push_back(tag);
        end
    endtask

    task automatic op(input logic [127:0] a, input logic [127:0] b,
                      input logic dw, input logic sg, input logic hi, input string tag);
        step(1'b1, a, b, dw, sg, hi, ref_mul(a, b, dw, sg, hi), tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        c32 = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_0000};
        c64 = '{64'h0, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE,
                64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000};

        // R8: in_valid offered during reset must be ignored
        repeat (4) begin
            @(negedge clk);
            check1(in_ready == 1'b0, "R8 ready in reset", 128'(in_ready), 128'd0);
            in_valid = 1'b1;
            in_a = {4{32'h1234_5678}};
            in_b = {4{32'h9ABC_DEF0}};
        end
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (LAT + 2) begin
            @(negedge clk);
            check1(out_valid == 1'b0, "R8 idle after reset", 128'(out_valid), 128'd0);
            check1(in_ready == 1'b1, "R8 ready after reset", 128'(in_ready), 128'd1);
        end

        // worked unsigned cases, literal expectations
        step(1'b1, {4{32'h8000_0000}}, {32'd7, 32'd6, 32'd5, 32'd4}, 1'b0, 1'b0, 1'b1,
             {32'd3, 32'd3, 32'd2, 32'd2}, "R1 worked");
        step(1'b1, {64'h3FFF_FFFF_FFFF_FFFF, 64'h1FFF_FFFF_FFFF_FFFF}, {64'd10, 64'd32},
             1'b1, 1'b0, 1'b1, {64'd2, 64'd3}, "R2 worked");
        // R3: low doubleword identical for both signedness settings
        step(1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001}, {64'h3, 64'hFFFF_FFFF_FFFF_FFFF},
             1'b1, 1'b1, 1'b0, {64'hFFFF_FFFF_FFFF_FFFD, 64'h7FFF_FFFF_FFFF_FFFF}, "R3 signed");
        step(1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001}, {64'h3, 64'hFFFF_FFFF_FFFF_FFFF},
             1'b1, 1'b0, 1'b0, {64'hFFFF_FFFF_FFFF_FFFD, 64'h7FFF_FFFF_FFFF_FFFF}, "R3 unsigned");
        // R6: all-ones words next to zero words, no carry leaks across lanes
        step(1'b1, {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF},
             {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF}, 1'b0, 1'b0, 1'b1,
             {32'h0, 32'hFFFF_FFFE, 32'h0, 32'hFFFF_FFFE}, "R6 isolation");

        // corner sweep over all eight modes
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [127:0] a, b;
                    logic dw, sg, hi;
                    dw = m[2]; sg = m[1]; hi = m[0];
                    if (!dw) begin
                        for (int k = 0; k < 4; k++) begin
                            a[32*k +: 32] = c32[(i + k) % 8];
                            b[32*k +: 32] = c32[(j + 3*k) % 8];
                        end
                    end else begin
                        for (int k = 0; k < 2; k++) begin
                            a[64*k +: 64] = c64[(i + 5*k) % 8];
                            b[64*k +: 64] = c64[(j + 3*k) % 8];
                        end
                    end
                    op(a, b, dw, sg, hi, mode_tag(dw, sg, hi));
                end
            end
        end

        // random operands with random idle gaps
        for (int n = 0; n < 1500; n++) begin
            logic [127:0] a, b;
            logic [2:0] m;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            m = 3'($urandom);
            if ($urandom % 4 == 0)
                step(1'b0, a, b, m[2], m[1], m[0], '0, "");
            else
                op(a, b, m[2], m[1], m[0], {mode_tag(m[2], m[1], m[0]), "/R6"});
        end

        repeat (LAT + 2) step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "");
        check1(q_due.size() == 0, "R7 all results seen", 128'(q_due.size()), 128'd0);
        finish_run();
    end
endmodule